// File: doc/BRIEF.md
# Buck Converter Startup and Fault Sequencer

This block is the digital supervisor of a synchronous step-down controller. It reads single-bit, clock-synchronous comparator results: supply good (hysteresis already applied), a shutdown request from the compensation node being pulled low, a feedback undervoltage flag, and an overcurrent trip sensed on the switch node while the low-side switch conducts. It also reads a one-cycle tick per switching period and a marker for each high-side pulse from the PWM stage. From these it produces the soft-start reference code for the reference DAC, separate enables for the high-side and low-side drivers, and status bits for the run, hiccup and latched-fault states.

All conditions share one fixed priority, from highest to lowest: supply lockout, shutdown, overcurrent latch, hiccup, normal run. The ramp rises one code step per switching tick, from zero to `SS_STEPS`. By default the step count is the switching frequency in kHz times two, so the ramp lasts about 2 ms. To protect a pre-biased output, the low-side driver stays off after each start until the first high-side pulse. A feedback undervoltage in run starts a hiccup. The block waits `HICCUP_TICKS` switching ticks and then ramps again from zero. An overcurrent trip stays latched until the supply flag drops and returns.

Top module: `buck_seq`

## Requirements
- R1: While `supply_ok` is low, after the next clock edge both driver enables, `run`, `hiccup` and `latched` are 0 and `ss_code` is 0.
- R2: With `supply_ok` high and no shutdown request, the first clock edge out of the off state enters soft start: `hs_en`=1, `ls_en`=0, `ss_code`=0.
- R3: During soft start `ss_code` rises by exactly one on each edge where `tick` is 1 and holds on edges where `tick` is 0.
- R4: On the tick that takes `ss_code` to `SS_STEPS`, `run` becomes 1. The code then holds at `SS_STEPS` while running.
- R5: `shdn_req` high, with the supply good, turns both drivers off and sets `ss_code` to 0 at the next edge. When the request is released, the ramp restarts from 0.
- R6: After each entry into soft start, `ls_en` stays 0 until an edge samples `hs_pulse`=1. It is 1 from that edge on, for as long as the drivers stay enabled.
- R7: `fb_low` is ignored during soft start: the ramp continues and `hiccup` stays 0.
- R8: `fb_low` in run causes, at the next edge, `hiccup`=1, `run`=0, both drivers off and `ss_code`=0.
- R9: In hiccup the block counts `HICCUP_TICKS` ticks. On the last one it re-enters soft start with `ss_code`=0, `hs_en`=1 and `ls_en`=0.
- R10: `ocp_trip` sampled while `ls_en` is 1 sets `latched`=1 and turns both drivers off at the next edge. `ocp_trip` while `ls_en` is 0 has no effect.
- R11: The latched state survives a shutdown request and its release. Only `supply_ok` going low clears it, and a new soft start then follows when the supply returns.
- R12: Supply lockout takes precedence over everything. Shutdown takes precedence over the fault and feedback inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Supply above lockout level (hysteresis applied) |
| shdn_req | input | 1 | Compensation node held below shutdown level |
| fb_low | input | 1 | Feedback below undervoltage level |
| ocp_trip | input | 1 | Switch node below overcurrent threshold |
| tick | input | 1 | One-cycle pulse per switching period |
| hs_pulse | input | 1 | High-side pulse occurred this cycle |
| ss_code | output | CODE_W | Soft-start reference code, 0 to SS_STEPS |
| hs_en | output | 1 | High-side driver enable |
| ls_en | output | 1 | Low-side driver enable |
| run | output | 1 | Soft start complete, regulating |
| hiccup | output | 1 | Waiting in hiccup |
| latched | output | 1 | Overcurrent latch-off active |

## Verification
Every output is a register or a decode of registers, so each result is due exactly one clock edge after the inputs that caused it are sampled. No output responds in the same cycle. The bench changes inputs on the falling edge. Its driver task then pushes the expected outputs for the following rising edge into a queue. The monitor pops and compares each item one time unit after that edge. Multi-tick effects (the end of the ramp and the hiccup wait) are checked edge by edge, so both an early and a late transition show up.

// File: rtl/buck_seq.sv
module buck_seq #(
  parameter int SW_FREQ_KHZ  = 300,
  parameter int SS_STEPS     = SW_FREQ_KHZ * 2,
  parameter int HICCUP_TICKS = 2048,
  localparam int CODE_W      = $clog2(SS_STEPS + 1),
  localparam int HIC_W       = $clog2(HICCUP_TICKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              shdn_req,
  input  logic              fb_low,
  input  logic              ocp_trip,
  input  logic              tick,
  input  logic              hs_pulse,
  output logic [CODE_W-1:0] ss_code,
  output logic              hs_en,
  output logic              ls_en,
  output logic              run,
  output logic              hiccup,
  output logic              latched
);

  typedef enum logic [2:0] {S_OFF, S_SOFT, S_RUN, S_HIC, S_LATCH} st_t;

  localparam logic [CODE_W-1:0] CODE_TOP = CODE_W'(SS_STEPS);
  localparam logic [HIC_W-1:0]  HIC_TOP  = HIC_W'(HICCUP_TICKS - 1);

  st_t              state;
  logic [CODE_W-1:0] code;
  logic [HIC_W-1:0]  hcnt;
  logic              hs_seen;

  assign ss_code = code;
  assign hs_en   = (state == S_SOFT) || (state == S_RUN);
  assign ls_en   = hs_en && hs_seen;
  assign run     = (state == S_RUN);
  assign hiccup  = (state == S_HIC);
  assign latched = (state == S_LATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_OFF;
      code    <= '0;
      hcnt    <= '0;
      hs_seen <= 1'b0;
    end else if (!supply_ok) begin
      state   <= S_OFF;
      code    <= '0;
      hcnt    <= '0;
      hs_seen <= 1'b0;
    end else if (state == S_LATCH) begin
      code    <= '0;
      hs_seen <= 1'b0;
    end else if (shdn_req) begin
      state   <= S_OFF;
      code    <= '0;
      hcnt    <= '0;
      hs_seen <= 1'b0;
    end else if (ocp_trip && ls_en) begin
      state   <= S_LATCH;
      code    <= '0;
      hs_seen <= 1'b0;
    end else begin
      case (state)
        S_OFF: begin
          state   <= S_SOFT;
          code    <= '0;
          hs_seen <= 1'b0;
        end
        S_SOFT: begin
          hs_seen <= hs_seen | hs_pulse;
          if (tick) begin
            code <= code + 1'b1;
            if (code == CODE_TOP - 1'b1) state <= S_RUN;
          end
        end
        S_RUN: begin
          if (fb_low) begin
            state   <= S_HIC;
            code    <= '0;
            hcnt    <= '0;
            hs_seen <= 1'b0;
          end else begin
            hs_seen <= hs_seen | hs_pulse;
          end
        end
        S_HIC: begin
          if (tick) begin
            if (hcnt == HIC_TOP) begin
              state <= S_SOFT;
              hcnt  <= '0;
            end else begin
              hcnt <= hcnt + 1'b1;
            end
          end
        end
        default: state <= S_OFF;
      endcase
    end
  end

  // R1
  lockout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!hs_en && !ls_en && !latched && ss_code == '0));

  // R5
  shutdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && shdn_req) |=> (!hs_en && !ls_en && !run && ss_code == '0));

  // R3
  ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !shdn_req && !ocp_trip && hs_en && !run && !tick) |=> $stable(ss_code));

  // R6
  prebias_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> $past(hs_pulse));

  // R10
  ocp_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !shdn_req && ls_en && ocp_trip) |=> (latched && !hs_en));

  // R11
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && supply_ok) |=> latched);

endmodule

// File: tb/tb_buck_seq.sv
module tb_buck_seq;
  localparam int SS = 5;
  localparam int HT = 6;
  localparam int CW = $clog2(SS + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_ok = 0, shdn_req = 0, fb_low = 0, ocp_trip = 0, tick = 0, hs_pulse = 0;
  logic [CW-1:0] ss_code;
  logic hs_en, ls_en, run, hiccup, latched;

  int errors = 0, checks = 0;
  bit done = 0;

  typedef struct {logic [4:0] flags; int code; string tag;} exp_t;
  exp_t q[$];
  event sample_ev;

  buck_seq #(.SS_STEPS(SS), .HICCUP_TICKS(HT)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .shdn_req(shdn_req),
    .fb_low(fb_low), .ocp_trip(ocp_trip), .tick(tick), .hs_pulse(hs_pulse),
    .ss_code(ss_code), .hs_en(hs_en), .ls_en(ls_en), .run(run),
    .hiccup(hiccup), .latched(latched));

  always #10 clk = ~clk;

  always @(sample_ev) begin
    while (q.size() > 0) begin
      exp_t e;
      logic [4:0] act;
      e = q.pop_front();
      act = {hs_en, ls_en, run, hiccup, latched};
      checks++;
      if (act !== e.flags || int'(ss_code) != e.code) begin
        errors++;
        $display("FAIL %s: hs/ls/run/hic/lat=%b code=%0d expected %b code=%0d",
                 e.tag, act, ss_code, e.flags, e.code);
      end
    end
  end

  task automatic chk(input logic [4:0] fl, input int code, input string tag);
    exp_t e;
    e.flags = fl; e.code = code; e.tag = tag;
    q.push_back(e);
    -> sample_ev;
    #1;
  endtask

  task automatic step(input logic sup, sd, fb, oc, tk, hp,
                      input logic [4:0] fl, input int code, input string tag);
    @(negedge clk);
    supply_ok = sup; shdn_req = sd; fb_low = fb; ocp_trip = oc; tick = tk; hs_pulse = hp;
    @(posedge clk); #1;
    chk(fl, code, tag);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 chk(5'b00000, 0, "R1 reset");
    @(negedge clk) rst_n = 1'b1;
    //    sup sd fb oc tk hp   hs ls run hic lat
    step(0, 0, 0, 0, 0, 0, 5'b00000, 0, "R1 lockout");
    step(1, 0, 0, 0, 0, 0, 5'b10000, 0, "R2 start");
    step(1, 0, 0, 0, 1, 0, 5'b10000, 1, "R3 step");
    step(1, 0, 0, 0, 0, 0, 5'b10000, 1, "R3 hold");
    step(1, 0, 0, 1, 0, 0, 5'b10000, 1, "R10 ocp ignored");
    step(1, 0, 1, 0, 1, 0, 5'b10000, 2, "R7 fb ignored");
    step(1, 0, 0, 0, 0, 1, 5'b11000, 2, "R6 ls after pulse");
    step(1, 0, 0, 0, 1, 0, 5'b11000, 3, "R3 step");
    step(1, 0, 0, 0, 1, 0, 5'b11000, 4, "R3 step");
    step(1, 0, 0, 0, 1, 0, 5'b11100, 5, "R4 run");
    step(1, 0, 0, 0, 1, 0, 5'b11100, 5, "R4 hold");
    step(1, 0, 1, 0, 0, 0, 5'b00010, 0, "R8 hiccup");
    for (int i = 0; i < HT - 1; i++)
      step(1, 0, 0, 0, 1, 0, 5'b00010, 0, "R9 wait");
    step(1, 0, 0, 0, 1, 0, 5'b10000, 0, "R9 restart");
    step(1, 0, 0, 0, 1, 0, 5'b10000, 1, "R9 ramp");
    step(1, 1, 0, 0, 0, 0, 5'b00000, 0, "R5 shutdown");
    step(1, 0, 0, 0, 0, 0, 5'b10000, 0, "R5 release");
    step(1, 0, 0, 0, 0, 1, 5'b11000, 0, "R6 pulse");
    step(1, 0, 0, 1, 0, 0, 5'b00001, 0, "R10 latch");
    step(1, 1, 0, 0, 0, 0, 5'b00001, 0, "R11 shdn keeps latch");
    step(1, 0, 0, 0, 1, 0, 5'b00001, 0, "R11 release keeps latch");
    step(0, 0, 0, 0, 0, 0, 5'b00000, 0, "R11 supply clears");
    step(1, 0, 0, 0, 0, 0, 5'b10000, 0, "R11 restart");
    step(1, 0, 0, 0, 0, 1, 5'b11000, 0, "R6 pulse");
    step(1, 0, 0, 1, 0, 0, 5'b00001, 0, "R10 latch");
    step(0, 1, 0, 1, 0, 0, 5'b00000, 0, "R12 lockout first");
    step(1, 1, 1, 1, 1, 1, 5'b00000, 0, "R12 shutdown over faults");
    step(1, 0, 0, 0, 0, 0, 5'b10000, 0, "R12 release");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule